// File: doc/BRIEF.md
# Serial Flash Read Responder

This block is the device side of a byte-wide serial flash, reduced to the read path. The host lowers chip select, clocks in a command byte and a three-byte address on SI, and the block then streams bytes out of its internal array on SO. Each transfer is most significant bit first. The address steps up after every byte and rolls over at the top of the array. The stream continues for as long as the host keeps clocking. Raising chip select ends the transfer and floats SO.

Two commands are recognised. A plain read returns data straight after the address. A fast read inserts one dummy byte before the data. Both commands share the same address and output datapath. SCK, CS and SI are brought into the `clk` domain through a synchronizer, and all edges are detected there. For this reason SCK must stay at each level for at least four `clk` periods. The array is filled through a parallel write port, which the test bench uses to preload contents.

The controller has six states. ST_IDLE (deselected) moves to ST_CMD when chip select goes low. ST_CMD leaves at the end of the command byte: it moves to ST_ADDR on a recognised opcode and to ST_IGNORE on any other. ST_ADDR moves after the third address byte, to ST_DUMMY for a fast read or to ST_DATA for a plain read. ST_DUMMY moves to ST_DATA after one byte. ST_DATA and ST_IGNORE hold until deselect. Chip select high forces ST_IDLE from any state.

Top module: `spird_top`

## Requirements
- R1: Whenever chip select is high, and after reset, SO is high impedance and `so_oe` is 0.
- R2: Opcode 8'h03 followed by a 24-bit address (sampled on rising SCK edges) produces data. The first data bit appears on the SCK fall that follows the 32nd rising edge, and SO stays high impedance until then.
- R3: Opcode 8'h0B takes the same address and then eight dummy bits. Data starts on the SCK fall after the 40th rising edge, and SO stays high impedance through the dummy byte.
- R4: Continued clocking streams consecutive bytes from successive addresses without a new command.
- R5: After the byte at the top array address (2^ARRAY_AW−1), output continues from address 0.
- R6: Only the low ARRAY_AW address bits select the byte. The higher received address bits have no effect.
- R7: Any other opcode leaves SO high impedance and `so_oe` at 0 for the rest of that selection.
- R8: Raising chip select in the middle of a byte aborts the transfer. The next selection starts with a fresh opcode byte.
- R9: Both SCK idle low (mode 0) and SCK idle high (mode 3) give the same results.
- R10: A `clk` cycle with `wr_en` high stores `wr_data` at `wr_addr`, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out, high impedance when not driving |
| so_oe | output | 1 | High while SO is driven |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | ARRAY_AW | Array write address |
| wr_data | input | 8 | Array write data |

## Verification
The hardest case to reach is the rollover from the top array address to zero in the middle of a stream. The bench reaches it by starting a read two bytes below the top address and clocking four bytes, so the crossing sits between the second and third bytes. A second hard case is a chip-select rise partway through the opcode byte. The bench clocks only four bits before deselecting, then issues a complete read and checks that its data is correct, which shows that no stale bit count survived the abort.

// File: rtl/spird_pkg.sv
package spird_pkg;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_FAST = 8'h0B;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } spird_state_t;

endpackage

// File: rtl/spird_sync.sv
module spird_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    localparam int CHAIN_W = STAGES * W;

    logic [CHAIN_W-1:0] chain;

    if (STAGES == 1) begin : g_single
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
        end
    end else begin : g_multi
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[CHAIN_W-W-1:0], d};
        end
    end

    assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/spird_mem.sv
module spird_mem #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) arr[wr_addr] <= wr_data;
    end

    assign rd_data = arr[rd_addr];

endmodule

// File: rtl/spird_fsm.sv
module spird_fsm
    import spird_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          sck_s,
    input  logic          si_s,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          so_bit,
    output logic          so_oe
);

    localparam int ADDR_BYTES = 3;

    spird_state_t st, st_d;
    logic         sck_q;
    logic [2:0]   bitcnt;
    logic [1:0]   abyte;
    logic [7:0]   shin;
    logic [7:0]   oreg;
    logic [AW-1:0] addr;
    logic         fast;
    logic         sck_rise, sck_fall, byte_done;
    logic [7:0]   opcode;

    assign sck_rise  = !cs_hi && sck_s && !sck_q;
    assign sck_fall  = !cs_hi && !sck_s && sck_q;
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign opcode    = {shin[6:0], si_s};
    assign rd_addr   = addr;

    always_comb begin
        st_d = st;
        if (cs_hi) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:   st_d = ST_CMD;
                ST_CMD:    if (byte_done)
                               st_d = (opcode == OP_READ || opcode == OP_FAST) ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (byte_done && abyte == 2'(ADDR_BYTES - 1))
                               st_d = fast ? ST_DUMMY : ST_DATA;
                ST_DUMMY:  if (byte_done) st_d = ST_DATA;
                ST_DATA:   st_d = ST_DATA;
                ST_IGNORE: st_d = ST_IGNORE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    // input-side datapath: edge history, bit/byte counters, address capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            bitcnt <= '0;
            abyte  <= '0;
            shin   <= '0;
            addr   <= '0;
            fast   <= 1'b0;
        end else begin
            sck_q <= sck_s;
            if (cs_hi) begin
                bitcnt <= '0;
                abyte  <= '0;
            end else begin
                if (sck_rise) begin
                    bitcnt <= bitcnt + 3'd1;
                    shin   <= opcode;
                end
                if (st == ST_CMD && byte_done)
                    fast <= (opcode == OP_FAST);
                if (st == ST_ADDR && sck_rise)
                    addr <= {addr[AW-2:0], si_s};
                if (st == ST_ADDR && byte_done)
                    abyte <= abyte + 2'd1;
                if (st == ST_DATA && sck_fall && bitcnt == 3'd0)
                    addr <= addr + 1'b1;
            end
        end
    end

    // output process: shift register and drive enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oreg  <= '0;
            so_oe <= 1'b0;
        end else if (cs_hi) begin
            so_oe <= 1'b0;
        end else if (st == ST_DATA && sck_fall) begin
            so_oe <= 1'b1;
            if (bitcnt == 3'd0) oreg <= rd_data;
            else                oreg <= {oreg[6:0], 1'b0};
        end
    end

    assign so_bit = oreg[7];

    // R1
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !so_oe);

    // R2
    drive_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> st == ST_DATA);

    // R3
    dummy_only_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DUMMY |-> fast);

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DATA && sck_fall && bitcnt == 3'd0) |=> addr == AW'($past(addr) + 1'b1));

    // R7
    ignore_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGNORE && !cs_hi) |=> (st == ST_IGNORE || cs_hi) && !so_oe);

endmodule

// File: rtl/spird_top.sv
module spird_top #(
    parameter int ARRAY_AW    = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sck,
    input  logic                si,
    output logic                so,
    output logic                so_oe,
    input  logic                wr_en,
    input  logic [ARRAY_AW-1:0] wr_addr,
    input  logic [7:0]          wr_data
);

    logic [2:0]          pins_s;
    logic [ARRAY_AW-1:0] rd_addr;
    logic [7:0]          rd_data;
    logic                so_bit;

    spird_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si}),
        .q     (pins_s)
    );

    spird_mem #(.AW(ARRAY_AW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    spird_fsm #(.AW(ARRAY_AW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_hi   (pins_s[2]),
        .sck_s   (pins_s[1]),
        .si_s    (pins_s[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .so_bit  (so_bit),
        .so_oe   (so_oe)
    );

    assign so = so_oe ? so_bit : 1'bz;

endmodule

// File: tb/spird_top_test.sv
`timescale 1ns/1ps
module spird_top_test;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int H     = 32;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    wire           so;
    wire           so_oe;

    int  n_chk = 0, n_fail = 0;
    bit  done = 0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    spird_top #(.ARRAY_AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 13) + (i >> 8) * 7 + 5);
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_z(string req, string what);
        chk(req, what, {31'd0, so}, {31'd0, 1'bz});
        chk(req, {what, " oe"}, {31'd0, so_oe}, 32'd0);
    endtask

    task automatic write_byte(logic [AW-1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = b[i]; #H;
            sck = 1'b1; #H;
        end
    endtask

    task automatic recv_byte(output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; #H;
            b[i] = so;
            sck = 1'b1; #H;
        end
    endtask

    task automatic begin_xfer(bit mode3);
        sck = mode3; #H;
        cs_n = 1'b0; #H;
    endtask

    task automatic end_xfer(bit mode3);
        sck = mode3; #H;
        cs_n = 1'b1; #H;
        chk_z("R1", "SO after deselect");
    endtask

    task automatic do_read(string req, bit mode3, bit fast, logic [23:0] a, int n);
        logic [7:0] b;
        begin_xfer(mode3);
        send_byte(fast ? 8'h0B : 8'h03);
        send_byte(a[23:16]);
        send_byte(a[15:8]);
        send_byte(a[7:0]);
        if (fast) begin
            chk_z(req, "SO before dummy");
            send_byte(8'h5A);
        end
        chk_z(req, "SO before first data fall");
        for (int k = 0; k < n; k++) begin
            recv_byte(b);
            chk(req, $sformatf("byte %0d", k), {24'd0, b},
                {24'd0, model[(int'(a[AW-1:0]) + k) % DEPTH]});
        end
        end_xfer(mode3);
    endtask

    task automatic t_reset;
        chk_z("R1", "SO after reset");
    endtask

    task automatic t_plain_read;     // R2, R4
        do_read("R2", 1'b0, 1'b0, 24'h000010, 2);
        do_read("R4", 1'b0, 1'b0, 24'h000155, 8);
    endtask

    task automatic t_fast_read;      // R3
        do_read("R3", 1'b0, 1'b1, 24'h000321, 3);
    endtask

    task automatic t_mode3;          // R9
        do_read("R9", 1'b1, 1'b0, 24'h000400, 3);
        do_read("R9", 1'b1, 1'b1, 24'h0006F0, 2);
    endtask

    task automatic t_wrap;           // R5
        do_read("R5", 1'b0, 1'b0, 24'(DEPTH - 2), 4);
        do_read("R5", 1'b1, 1'b1, 24'(DEPTH - 1), 2);
    endtask

    task automatic t_upper_bits;     // R6
        do_read("R6", 1'b0, 1'b0, 24'hF80123, 2);
        do_read("R6", 1'b0, 1'b1, 24'h07F9AB, 2);
    endtask

    task automatic t_bad_opcode;     // R7
        logic [7:0] b;
        begin_xfer(1'b0);
        send_byte(8'h9F);
        send_byte(8'h00);
        send_byte(8'h00);
        send_byte(8'h10);
        for (int k = 0; k < 2; k++) begin
            recv_byte(b);
            chk("R7", "SO floating after unknown opcode", {24'd0, b}, {24'd0, 8'bzzzzzzzz});
            chk("R7", "so_oe after unknown opcode", {31'd0, so_oe}, 32'd0);
        end
        end_xfer(1'b0);
        do_read("R7", 1'b0, 1'b0, 24'h000010, 1);
    endtask

    task automatic t_abort;          // R8
        begin_xfer(1'b0);
        for (int i = 7; i >= 4; i--) begin
            sck = 1'b0; si = 1'b0; #H;
            sck = 1'b1; #H;
        end
        sck = 1'b0; #H;
        cs_n = 1'b1; #H;
        chk_z("R8", "SO after mid-byte abort");
        do_read("R8", 1'b0, 1'b0, 24'h000123, 2);
    endtask

    task automatic t_rewrite;        // R10
        write_byte(11'h055, 8'hC3);
        write_byte(11'h056, 8'h3C);
        do_read("R10", 1'b0, 1'b0, 24'h000054, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(i);
            model[i] = pat(i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        t_plain_read();
        t_fast_read();
        t_mode3();
        t_wrap();
        t_upper_bits();
        t_bad_opcode();
        t_abort();
        t_rewrite();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule